// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that gives a bus master byte access to 2048 bytes of internal storage. The bus lines are oversampled with the system clock, which must run at least eight times faster than the bus clock. Start and Stop conditions and the bus clock edges are recognised on the synchronised lines. The first byte after a Start is the slave address. It carries a device-type code, a three-bit page number that supplies the upper three bits of the 11-bit address, and a direction bit.

A write transfer sends one word byte, which gives the low eight address bits, and then any number of data bytes. Each data byte is committed to storage when its last bit arrives, before the acknowledge, so a write never adds delay. A read transfer has no word byte. It starts from the retained address latch and continues as long as the master acknowledges. A random read is a write that stops after its word byte, followed by a repeated Start and a read. A write-protect input blocks all data writes.

The data line is driven through an output enable. When `sda_oe` is high the pad pulls the line low. When it is low the line is released to the external pull-up.

Top module: `twi_fram_slave`

## Requirements
- R1: A Start (data line falling while the clock line is high) aborts any transfer and makes the slave wait for a slave address. A Stop (data line rising while the clock line is high) ends any transfer. After reset and after a Stop, `sda_oe` is 0.
- R2: The slave address arrives MSB first. When its bits 7:4 equal 1010b, the slave acknowledges by pulling the data line low during the 9th clock. Any other value is not acknowledged, and the following bytes are neither acknowledged nor acted on until the next Start.
- R3: A write uses a slave address with bit 0 = 0 and bits 3:1 = page P, followed by an acknowledged word byte W. The first data byte, sent MSB first and acknowledged, is stored at address {P, W}.
- R4: After each data byte is stored, the 11-bit address increments, wrapping from 7FFh to 000h. A burst may be of any length.
- R5: A read uses a slave address with bit 0 = 1 and has no word byte. The first byte comes from {P of this slave address, low 8 bits of the address latch}. The latch holds the address that follows the last byte accessed.
- R6: During a read, the slave drives the next sequential byte each time the master acknowledges. After a no-acknowledge in the 9th clock, the slave releases the data line (`sda_oe` = 0).
- R7: A write made of a slave address and a word byte, followed by a repeated Start and a read slave address, returns the byte stored at {P, W}.
- R8: A Start or a Stop that arrives before the 8th bit of a data byte leaves storage unchanged and leaves the address latch where the word byte set it.
- R9: While `wp_i` is 1, data bytes are not acknowledged, storage is unchanged and the address does not increment. The slave address and the word byte are still acknowledged.
- R10: `sda_oe` changes only while the clock line is low, except on a Start or a Stop.
- R11: A sequential read that passes address 7FFh continues at 000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release it |
| wp_i | input | 1 | Write protect, 1 blocks data writes |

## Verification
The assertions check the following on every cycle:
- the state after each Start and Stop;
- that an acknowledge to a slave address is given only for the 1010b device type;
- that the address steps by exactly one with wrap;
- that the address stays frozen under write protect;
- that the output enable holds steady while the clock line is high.

Several behaviours depend on storage contents and on the address latch carried across transfers, so only the bench scenarios can show them:
- correct data placement;
- current-address reads from a new page;
- random reads;
- wrap on both write and read;
- that aborted writes leave bytes untouched;
- that bytes sent after a device-type mismatch are ignored.

// File: rtl/twi_mem_pkg.sv
// Shared constants and types for the two-wire memory slave.
package twi_mem_pkg;
    localparam int ADDR_W   = 11;
    localparam int DATA_W   = 8;
    localparam int TYPE_W   = 4;
    localparam logic [TYPE_W-1:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring the bus until a Start
        ST_DEV,    // receiving the slave address
        ST_WORD,   // receiving the low address byte
        ST_WR,     // receiving data bytes
        ST_RD      // transmitting data bytes
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// Multi-flop synchronizer for a group of asynchronous input lines.
// Assumes STAGES >= 2; every line resets to 1 (idle bus level).
module twi_line_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    output logic [LINES-1:0] lines_s
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        // Shift the raw line through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], lines_i[g]};
        end

        assign lines_s[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/twi_cond_det.sv
// Detects bus clock edges and Start/Stop conditions on synchronised lines.
// Assumes both inputs come through equal-length synchronizers.
module twi_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_d, sda_d;

    // Keep the previous sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_mem_array.sv
// Register-array storage: synchronous write, combinational read.
// Contents are not reset; only written locations hold defined data.
module twi_mem_array #(
    parameter int ADDR_W = twi_mem_pkg::ADDR_W,
    parameter int DATA_W = twi_mem_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store one byte when the protocol engine commits it.
    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/twi_slave_fsm.sv
// Protocol engine: decodes the slave address, keeps the address latch,
// receives write bytes and shifts out read bytes with acknowledges.
// Assumes edge and condition strobes last one cycle and that the system
// clock is at least 8x the bus clock.
module twi_slave_fsm
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W = twi_mem_pkg::ADDR_W,
    parameter int DATA_W = twi_mem_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              wp_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sda_oe
);
    localparam int PAGE_W = ADDR_W - DATA_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

    twi_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-2:0] sh_q;
    logic [DATA_W-2:0] tx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              ack_ph_q, ack_ok_q, rw_q, mack_q, oe_q;
    logic [DATA_W-1:0] rx_byte;
    logic              last_rise, rx_st, addr_step;

    assign rx_byte   = {sh_q, sda_s};
    assign last_rise = scl_rise && !ack_ph_q && (cnt_q == LAST_BIT);
    assign rx_st     = (st_q == ST_DEV) || (st_q == ST_WORD) || (st_q == ST_WR);
    assign mem_we    = (st_q == ST_WR) && last_rise && !wp_s;
    assign addr_step = mem_we || ((st_q == ST_RD) && last_rise);
    assign mem_addr  = addr_q;
    assign mem_wdata = rx_byte;
    assign sda_oe    = oe_q;

    // Sequence the bus protocol one edge or condition at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            sh_q     <= '0;
            tx_q     <= '0;
            addr_q   <= '0;
            ack_ph_q <= 1'b0;
            ack_ok_q <= 1'b0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else if (start_ev) begin
            st_q     <= ST_DEV;
            cnt_q    <= '0;
            ack_ph_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (stop_ev) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            ack_ph_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (rx_st) begin
            if (scl_rise && !ack_ph_q && cnt_q != FULL) begin
                sh_q  <= rx_byte[DATA_W-2:0];
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == LAST_BIT) begin
                    case (st_q)
                        ST_DEV: begin
                            ack_ok_q <= (rx_byte[DATA_W-1 -: TYPE_W] == DEV_TYPE);
                            rw_q     <= rx_byte[0];
                            if (rx_byte[DATA_W-1 -: TYPE_W] == DEV_TYPE)
                                addr_q[ADDR_W-1 -: PAGE_W] <= rx_byte[PAGE_W:1];
                        end
                        ST_WORD: begin
                            ack_ok_q            <= 1'b1;
                            addr_q[DATA_W-1:0] <= rx_byte;
                        end
                        default: begin
                            ack_ok_q <= !wp_s;
                            if (addr_step) addr_q <= addr_q + ADDR_W'(1);
                        end
                    endcase
                end
            end else if (scl_fall && !ack_ph_q && cnt_q == FULL) begin
                ack_ph_q <= 1'b1;
                oe_q     <= ack_ok_q;
            end else if (scl_fall && ack_ph_q) begin
                ack_ph_q <= 1'b0;
                cnt_q    <= '0;
                oe_q     <= 1'b0;
                if (st_q == ST_DEV) begin
                    if (!ack_ok_q) begin
                        st_q <= ST_IDLE;
                    end else if (rw_q) begin
                        st_q <= ST_RD;
                        tx_q <= mem_rdata[DATA_W-2:0];
                        oe_q <= ~mem_rdata[DATA_W-1];
                    end else begin
                        st_q <= ST_WORD;
                    end
                end else if (st_q == ST_WORD) begin
                    st_q <= ST_WR;
                end
            end
        end else if (st_q == ST_RD) begin
            if (scl_rise && !ack_ph_q && cnt_q != FULL) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (addr_step) addr_q <= addr_q + ADDR_W'(1);
            end else if (scl_fall && !ack_ph_q && cnt_q != FULL) begin
                oe_q <= ~tx_q[DATA_W-2];
                tx_q <= {tx_q[DATA_W-3:0], 1'b0};
            end else if (scl_fall && !ack_ph_q) begin
                oe_q     <= 1'b0;
                ack_ph_q <= 1'b1;
            end else if (scl_rise && ack_ph_q) begin
                mack_q <= !sda_s;
            end else if (scl_fall && ack_ph_q) begin
                ack_ph_q <= 1'b0;
                cnt_q    <= '0;
                if (mack_q) begin
                    tx_q <= mem_rdata[DATA_W-2:0];
                    oe_q <= ~mem_rdata[DATA_W-1];
                end else begin
                    st_q <= ST_IDLE;
                    oe_q <= 1'b0;
                end
            end
        end
    end

    // R1: a Start leaves the engine waiting for a slave address, line released
    a_r1_start_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q == ST_DEV && cnt_q == '0 && !oe_q));

    // R1: a Stop idles the engine with the line released
    a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st_q == ST_IDLE && !oe_q));

    // R2: an acknowledge to a slave address only follows the right device type
    a_r2_ack_needs_type: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEV && ack_ph_q && oe_q) |-> (sh_q[DATA_W-2 -: TYPE_W-1] == DEV_TYPE[TYPE_W-2:0]));

    // R4: each address step advances by exactly one, wrapping at the top
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_step && !start_ev && !stop_ev) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    // R9: in the data phase under write protect the address stays frozen
    a_r9_wp_freezes_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WR && wp_s) |=> $stable(addr_q));

    // R10: the output enable moves only after a clock-low sample
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(oe_q));
endmodule

// File: rtl/twi_fram_slave.sv
// Two-wire bus slave in front of a 2^ADDR_W byte register array.
// Assumes clk runs at least 8x the bus clock; sda_oe=1 pulls the line low.
module twi_fram_slave #(
    parameter int ADDR_W      = twi_mem_pkg::ADDR_W,
    parameter int DATA_W      = twi_mem_pkg::DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic wp_i
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] lines_s;
    logic scl_s, sda_s, wp_s;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    twi_line_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i ({wp_i, sda_i, scl_i}),
        .lines_s (lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];
    assign wp_s  = lines_s[2];

    twi_cond_det u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twi_slave_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .wp_s      (wp_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe)
    );

    twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );
endmodule

// File: tb/twi_fram_slave_tb_top.sv
module twi_fram_slave_tb_top;
    localparam int Q = 10;  // quarter bus-clock period in system clocks

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic rst_n, m_scl, m_sda, wp, sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    twi_fram_slave dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .wp_i   (wp)
    );

    localparam logic [18:0] VEC [8] = '{
        {11'h010, 8'h3C}, {11'h123, 8'h99}, {11'h200, 8'h01}, {11'h201, 8'h02},
        {11'h542, 8'h5A}, {11'h0AB, 8'hC3}, {11'h6F0, 8'h0F}, {11'h3FF, 8'hE7}
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit hold_ok = 1'b1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(Q);
        s = sda_bus;
        tick(Q - 1);
        if (sda_bus !== s) hold_ok = 1'b0;
        tick(1);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(nack, s);
    endtask

    task automatic set_addr(input logic [10:0] a, output logic ack_d, output logic ack_w);
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0}, ack_d);
        send_byte(a[7:0], ack_w);
    endtask

    task automatic read_at(input logic [10:0] a, output logic [7:0] d);
        logic k1, k2, k3;
        set_addr(a, k1, k2);
        bus_start();
        send_byte({4'hA, a[10:8], 1'b1}, k3);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    task automatic read_cur(input logic [2:0] pg, output logic [7:0] d);
        logic k;
        bus_start();
        send_byte({4'hA, pg, 1'b1}, k);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic a1, a2, a3;
        logic [7:0] d;
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0;
        tick(6);
        check("R1 reset sda_oe", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(6);

        // R3: table of single-byte writes; R7: random read of each
        foreach (VEC[i]) begin
            set_addr(VEC[i][18:8], a1, a2);
            send_byte(VEC[i][7:0], a3);
            bus_stop();
            check("R2 slave address ack", int'(a1), 1);
            check("R3 data ack", int'(a3), 1);
        end
        check("R1 sda_oe after stop", int'(sda_oe), 0);
        foreach (VEC[i]) begin
            read_at(VEC[i][18:8], d);
            check("R7 random read", int'(d), int'(VEC[i][7:0]));
        end

        // R2: wrong device type is not acked and later bytes are ignored
        bus_start();
        send_byte(8'hB0, a1);
        send_byte(8'h10, a2);
        send_byte(8'h55, a3);
        bus_stop();
        check("R2 bad type nack", int'(a1), 0);
        check("R2 ignored byte nack", int'(a2 | a3), 0);
        read_at(11'h010, d);
        check("R2 ignored data no write", int'(d), 8'h3C);

        // R4: sequential write across 7FFh
        set_addr(11'h7FE, a1, a2);
        send_byte(8'hA1, a1);
        send_byte(8'hA2, a2);
        send_byte(8'hA3, a3);
        bus_stop();
        check("R4 burst acks", int'(a1 & a2 & a3), 1);
        read_at(11'h000, d);
        check("R4 write wrapped to 000", int'(d), 8'hA3);

        // R6 and R11: sequential read across 7FFh
        set_addr(11'h7FE, a1, a2);
        bus_start();
        send_byte(8'hAF, a1);
        recv_byte(1'b0, d);
        check("R6 seq read byte0", int'(d), 8'hA1);
        recv_byte(1'b0, d);
        check("R6 seq read byte1", int'(d), 8'hA2);
        recv_byte(1'b1, d);
        check("R11 read wrapped to 000", int'(d), 8'hA3);
        check("R6 release after nack", int'(sda_oe), 0);
        bus_stop();

        // R5: current-address reads continue from the latch, page from slave address
        set_addr(11'h240, a1, a2);
        send_byte(8'h11, a1);
        send_byte(8'h22, a2);
        bus_stop();
        read_at(11'h240, d);
        check("R7 random read 240", int'(d), 8'h11);
        read_cur(3'd2, d);
        check("R5 current read 241", int'(d), 8'h22);
        read_cur(3'd5, d);
        check("R5 current read new page 542", int'(d), 8'h5A);

        // R8: Stop after six data bits leaves storage unchanged
        set_addr(11'h123, a1, a2);
        for (int i = 0; i < 6; i++) clk_bit(1'b0, a3);
        bus_stop();
        read_at(11'h123, d);
        check("R8 stop abort keeps byte", int'(d), 8'h99);

        // R8 and R1: repeated Start after four bits aborts; latch stays at word
        set_addr(11'h0AB, a1, a2);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, a3);
        bus_start();
        send_byte(8'hA1, a1);
        recv_byte(1'b1, d);
        bus_stop();
        check("R8 start abort then read 0AB", int'(d), 8'hC3);

        // R9: write protect
        wp = 1'b1;
        tick(6);
        set_addr(11'h200, a1, a2);
        check("R9 address bytes acked under wp", int'(a1 & a2), 1);
        send_byte(8'hEE, a1);
        send_byte(8'hEF, a2);
        bus_stop();
        check("R9 data nack under wp", int'(a1 | a2), 0);
        wp = 1'b0;
        tick(6);
        read_cur(3'd2, d);
        check("R9 no write, no increment", int'(d), 8'h01);

        check("R10 data line stable while clock high", int'(hold_ok), 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule